// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller

This block is the byte-buffering core of a classic serial port. It keeps one receive queue and one transmit queue, each sixteen bytes deep. It also carries out the commands written to the FIFO control byte. On the receive side it takes bytes from the deserializer and hands them to the host in arrival order. On the transmit side it takes bytes from the host and hands them to the serializer on request.

It produces the line-status bits that depend on queue state: data ready, overrun, holding register empty and transmitter empty. It also produces the receive fill count and the receive trigger level that a 2-bit field of the control byte selects. When the queues are disabled, each side acts as a single holding register, and a newer byte replaces an older one.

Serial shifting and error detection belong to other blocks. All state changes on the rising clock edge. The read data and the transmit head byte are combinational views of the queue heads.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the queues are disabled and both are empty, so data_ready_o=0, overrun_o=0, thre_o=1, temt_o=1 and rx_count_o=0. The trigger field is 0, so trig_level_o=1.
- R2: With the queues enabled (a control write with bit 0 = 1), received bytes are returned to the host in arrival order. rx_count_o rises by one for each byte taken, up to 16.
- R3: With the queues enabled, a byte that arrives while 16 bytes are held and no host read occurs in the same cycle is dropped. The count stays at 16 and overrun_o is set.
- R4: With the queues disabled, a byte that arrives while an unread byte is held replaces that byte, rx_count_o stays 1 and overrun_o is set.
- R5: A host read that removes the last held byte clears data_ready_o and overrun_o on the next cycle. rx_rdata_o is 0 whenever the receive side is empty, and data_ready_o is 1 exactly when rx_count_o is nonzero.
- R6: Control bits [7:6] select the receive trigger level. Value 0 gives 1, value 1 gives 4, value 2 gives 8 and value 3 gives 14.
- R7: A control write with bit 1 set empties the receive side and clears data_ready_o. A control write with bit 2 set empties the transmit side and sets thre_o and temt_o. In the cycle of such a write, a clear takes precedence over a push to the same side.
- R8: A control write with bit 0 = 0 while the queues are enabled empties both sides.
- R9: A host transmit write clears thre_o and temt_o. With the queues enabled, a write to a full transmit side (16 bytes) is dropped. With them disabled, a new write replaces the pending byte. After the transmitter has popped every byte, thre_o and temt_o are both 1, and a pop from an empty side has no effect.
- R10: When a push and a pop reach a non-empty side in the same cycle, its fill count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fcr_we_i | input | 1 | FIFO control byte write strobe |
| fcr_wdata_i | input | 8 | FIFO control byte: bit0 enable, bit1 receive clear, bit2 transmit clear, [7:6] trigger select |
| rx_rd_i | input | 1 | Host read of receive data (pops the head) |
| rx_rdata_o | output | 8 | Receive head byte, 0 when empty |
| tx_we_i | input | 1 | Host write of transmit data |
| tx_wdata_i | input | 8 | Transmit byte from host |
| rx_push_i | input | 1 | Received byte strobe from the deserializer |
| rx_byte_i | input | 8 | Received byte |
| tx_pop_i | input | 1 | Pop request from the serializer |
| tx_data_o | output | 8 | Transmit head byte, 0 when empty |
| data_ready_o | output | 1 | Receive data available |
| overrun_o | output | 1 | Receive overrun flag |
| thre_o | output | 1 | Transmit holding side empty |
| temt_o | output | 1 | Transmitter empty |
| rx_count_o | output | 5 | Receive fill count |
| trig_level_o | output | 5 | Decoded receive trigger level |

## Verification
A wrong pointer or count in a queue shows at the ports as an out-of-order or missing byte on rx_rdata_o or tx_data_o, at the next head read. It also shows as a wrong rx_count_o one cycle after the push or pop that caused it. A mode flag left in the wrong state shows up on the first byte that arrives against a full side: the replace-versus-drop outcome and the overrun flag differ one cycle later, and the next read shows which byte survived. A wrong clear or flush leaves the status bits wrong in the cycle after the control write.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned FIFO_DEPTH = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1);

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_sel_e;
endpackage

// File: rtl/trig_decode.sv
module trig_decode
  import uart_fifo_pkg::*;
#(
  parameter int unsigned LW = CNT_W
) (
  input  trig_sel_e         sel_i,
  output logic [LW-1:0]     level_o
);
  always_comb begin
    unique case (sel_i)
      TRIG_1:  level_o = LW'(1);
      TRIG_4:  level_o = LW'(4);
      TRIG_8:  level_o = LW'(8);
      default: level_o = LW'(14);
    endcase
  end
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          single_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          empty, room, do_pop, do_push, do_repl;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign room    = single_i ? empty : (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (room || do_pop);
  // single-register mode: newest byte overwrites the held one
  assign do_repl = push_i && single_i && !empty && !do_pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!clr_i) begin
      if (do_push)      mem_q[wr_q] <= din_i;
      else if (do_repl) mem_q[rd_q] <= din_i;
    end
  end

  assign dout_o  = empty ? '0 : mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fcr_we_i,
  input  logic [7:0]        fcr_wdata_i,
  input  logic              rx_rd_i,
  output logic [BYTE_W-1:0] rx_rdata_o,
  input  logic              tx_we_i,
  input  logic [BYTE_W-1:0] tx_wdata_i,
  input  logic              rx_push_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              tx_pop_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              data_ready_o,
  output logic              overrun_o,
  output logic              thre_o,
  output logic              temt_o,
  output logic [CNT_W-1:0]  rx_count_o,
  output logic [CNT_W-1:0]  trig_level_o
);
  logic             fifo_en_q, ovr_q;
  trig_sel_e        trig_q;
  logic             flush_all, rx_clr, tx_clr, rx_spill, rx_last;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic             unused_fcr;

  assign unused_fcr = ^fcr_wdata_i[5:3];
  assign flush_all  = fcr_we_i && fifo_en_q && !fcr_wdata_i[0];
  assign rx_clr     = (fcr_we_i && fcr_wdata_i[1]) || flush_all;
  assign tx_clr     = (fcr_we_i && fcr_wdata_i[2]) || flush_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      trig_q    <= TRIG_1;
    end else if (fcr_we_i) begin
      fifo_en_q <= fcr_wdata_i[0];
      trig_q    <= trig_sel_e'(fcr_wdata_i[7:6]);
    end
  end

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rx (
    .clk_i, .rst_ni,
    .clr_i    (rx_clr),
    .single_i (!fifo_en_q),
    .push_i   (rx_push_i),
    .din_i    (rx_byte_i),
    .pop_i    (rx_rd_i),
    .dout_o   (rx_rdata_o),
    .count_o  (rx_cnt)
  );

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_tx (
    .clk_i, .rst_ni,
    .clr_i    (tx_clr),
    .single_i (!fifo_en_q),
    .push_i   (tx_we_i),
    .din_i    (tx_wdata_i),
    .pop_i    (tx_pop_i),
    .dout_o   (tx_data_o),
    .count_o  (tx_cnt)
  );

  // byte lost (full) or replaced (single mode) without a read freeing space
  assign rx_spill = rx_push_i && !rx_clr && !(rx_rd_i && rx_cnt != '0) &&
                    (fifo_en_q ? (rx_cnt == CNT_W'(FIFO_DEPTH)) : (rx_cnt != '0));
  assign rx_last  = rx_rd_i && !rx_push_i && (rx_cnt == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_q <= 1'b0;
    else if (rx_spill) ovr_q <= 1'b1;
    else if (rx_last)  ovr_q <= 1'b0;
  end

  trig_decode #(.LW(CNT_W)) u_trig (.sel_i(trig_q), .level_o(trig_level_o));

  assign rx_count_o   = rx_cnt;
  assign data_ready_o = (rx_cnt != '0);
  assign overrun_o    = ovr_q;
  assign thre_o       = (tx_cnt == '0);
  assign temt_o       = (tx_cnt == '0);
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk
  import uart_fifo_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fcr_we_i,
  input logic [7:0]       fcr_wdata_i,
  input logic             rx_rd_i,
  input logic             rx_push_i,
  input logic             tx_we_i,
  input logic             tx_pop_i,
  input logic             data_ready_o,
  input logic             overrun_o,
  input logic             thre_o,
  input logic             temt_o,
  input logic [CNT_W-1:0] rx_count_o,
  input logic [CNT_W-1:0] trig_level_o
);
  // R2
  rx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count_o <= CNT_W'(FIFO_DEPTH));

  // R5
  last_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !rx_push_i && !fcr_we_i && rx_count_o == CNT_W'(1))
      |=> (!data_ready_o && !overrun_o));

  // R6
  trig_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_level_o == 5'd1) || (trig_level_o == 5'd4) ||
    (trig_level_o == 5'd8) || (trig_level_o == 5'd14));

  // R7
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_we_i && fcr_wdata_i[1]) |=> (rx_count_o == '0 && !data_ready_o));

  // R7
  tx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_we_i && fcr_wdata_i[2]) |=> (thre_o && temt_o));

  // R9
  tx_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_we_i && !fcr_we_i) |=> (!thre_o && !temt_o));

  // R9
  tx_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pop_i && thre_o && !tx_we_i) |=> thre_o);

  // R10
  rx_same_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_rd_i && rx_count_o != '0 && !fcr_we_i) |=> $stable(rx_count_o));
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk u_chk (.*);

// File: tb/uart_fifo_ctrl_bench.sv
module uart_fifo_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic fcr_we = 0, rx_rd = 0, tx_we = 0, rx_push = 0, tx_pop = 0;
  logic [7:0] fcr_d = 0, tx_wd = 0, rx_b = 0, rx_rdata, tx_data;
  logic dr, ovr, thre, temt;
  logic [4:0] rx_cnt, trig;
  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side model
  logic [7:0] rxq[$], txq[$];
  bit en = 0, m_ovr = 0;

  always #10 clk = ~clk;

  uart_fifo_ctrl u_uart_fifo_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fcr_we_i(fcr_we), .fcr_wdata_i(fcr_d),
    .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata), .tx_we_i(tx_we), .tx_wdata_i(tx_wd),
    .rx_push_i(rx_push), .rx_byte_i(rx_b), .tx_pop_i(tx_pop), .tx_data_o(tx_data),
    .data_ready_o(dr), .overrun_o(ovr), .thre_o(thre), .temt_o(temt),
    .rx_count_o(rx_cnt), .trig_level_o(trig));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic status(string req);
    chk({req, " count"}, rx_cnt, rxq.size());
    chk({req, " ready"}, dr, rxq.size() != 0);
    chk({req, " overrun"}, ovr, m_ovr);
    chk({req, " thre"}, thre, txq.size() == 0);
    chk({req, " temt"}, temt, txq.size() == 0);
  endtask

  // driver: deserializer byte
  task automatic rx_in(logic [7:0] b);
    if (en) begin
      if (rxq.size() < 16) rxq.push_back(b); else m_ovr = 1;
    end else begin
      if (rxq.size() > 0) begin rxq.delete(); m_ovr = 1; end
      rxq.push_back(b);
    end
    rx_push = 1; rx_b = b;
    @(negedge clk);
    rx_push = 0;
  endtask

  // monitor: host read compared against queue head
  task automatic host_rd(string req);
    logic [7:0] e;
    e = (rxq.size() > 0) ? rxq.pop_front() : 8'h00;
    chk({req, " rdata"}, rx_rdata, e);
    if (rxq.size() == 0) m_ovr = 0;
    rx_rd = 1;
    @(negedge clk);
    rx_rd = 0;
  endtask

  task automatic tx_wr(logic [7:0] b);
    if (en) begin
      if (txq.size() < 16) txq.push_back(b);
    end else begin
      txq.delete(); txq.push_back(b);
    end
    tx_we = 1; tx_wd = b;
    @(negedge clk);
    tx_we = 0;
  endtask

  task automatic tx_take(string req);
    logic [7:0] e;
    e = (txq.size() > 0) ? txq.pop_front() : 8'h00;
    chk({req, " txdata"}, tx_data, e);
    tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
  endtask

  task automatic fcr(logic [7:0] v);
    if (en && !v[0]) begin rxq.delete(); txq.delete(); end
    if (v[1]) rxq.delete();
    if (v[2]) txq.delete();
    en = v[0];
    fcr_we = 1; fcr_d = v;
    @(negedge clk);
    fcr_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    status("R1");
    chk("R1 trig", trig, 1);
    chk("R5 empty rdata", rx_rdata, 0);

    // R4 single-register receive
    rx_in(8'h11);
    rx_in(8'h22);
    status("R4");
    host_rd("R4");
    status("R5 single");

    // R9 single-register transmit replaces
    tx_wr(8'hA1);
    tx_wr(8'hA2);
    status("R9 single");
    tx_take("R9 single");
    status("R9 drained");

    // R2 / R3 queue mode
    fcr(8'h01);
    for (int i = 0; i < 16; i++) rx_in(8'h40 + 8'(i));
    status("R2 full");
    rx_in(8'hEE);
    status("R3");
    // R10 push and pop together on a full queue
    begin
      logic [7:0] e;
      e = rxq.pop_front();
      rxq.push_back(8'h77);
      chk("R10 head", rx_rdata, e);
      rx_rd = 1; rx_push = 1; rx_b = 8'h77;
      @(negedge clk);
      rx_rd = 0; rx_push = 0;
      chk("R10 count", rx_cnt, 16);
    end
    for (int i = 0; i < 16; i++) host_rd("R2");
    status("R5 last");
    host_rd("R5 empty");

    // R6
    fcr(8'h41); chk("R6 sel1", trig, 4);
    fcr(8'h81); chk("R6 sel2", trig, 8);
    fcr(8'hC1); chk("R6 sel3", trig, 14);
    fcr(8'h01); chk("R6 sel0", trig, 1);

    // R9 queue mode, full drop
    for (int i = 0; i < 17; i++) tx_wr(8'h80 + 8'(i));
    status("R9 full");
    for (int i = 0; i < 16; i++) tx_take("R9");
    status("R9 empty");
    tx_take("R9 pop empty");
    status("R9 pop empty");

    // R7 clears
    rx_in(8'h01); rx_in(8'h02); rx_in(8'h03);
    tx_wr(8'h04); tx_wr(8'h05);
    fcr(8'h03);
    status("R7 rx clear");
    tx_take("R7 tx kept");
    fcr(8'h05);
    status("R7 tx clear");

    // R8 disable flushes both
    rx_in(8'h09); rx_in(8'h0A);
    tx_wr(8'h0B); tx_wr(8'h0C);
    fcr(8'h00);
    status("R8");
    rx_in(8'h5A);
    host_rd("R8 single after");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule